// File: doc/BRIEF.md
# Dual-Rate Token Bucket Shaper

This block limits traffic for one scheduling node. It keeps two credit buckets: a peak bucket and a committed bucket. Each bucket has its own refill rate, its own depth and its own enable. Rates and depths are written in a compact floating-point-like code. The code takes a base of (256 + mantissa) and shifts it by an exponent. Credit is added on the ticks of a per-bucket time wheel. The wheel period is a fixed cycle count, shifted left by a divider exponent.

A scheduler reads the two conformance flags for the node's pending packet. When it sends a packet, it raises a one-cycle strobe together with the packet's byte length. That length is then charged against both buckets.

Software sets each bucket through a small write port. Every write loads the chosen bucket to full and restarts that bucket's wheel.

Top module: `dual_rate_shaper`

## Requirements
- R1: After reset, both buckets are disabled, and `peak_ok` and `commit_ok` both read 1.
- R2: A write with `cfg_we`=1 updates one bucket: `cfg_sel`=0 selects the peak bucket and `cfg_sel`=1 selects the committed bucket. The write word is laid out as follows: rate mantissa in bits 7:0, rate exponent in bits 11:8, divider exponent in bits 15:12, burst mantissa in bits 23:16, burst exponent in bits 27:24, enable in bit 28. The write sets the bucket level to its full depth and restarts its wheel.
- R3: On each refill event, an enabled bucket gains ((256 + rate mantissa) << rate exponent) / 256 bytes. Fractions are kept to 1/256 byte.
- R4: A bucket's refill events fall every (WHEEL_TICKS << d) cycles after its last write. Here d is the divider exponent, and values above 12 are treated as 12.
- R5: A bucket never holds more than ((256 + burst mantissa) << (burst exponent + 1)) / 256 bytes. Credit beyond that depth is discarded.
- R6: A `send_valid` strobe subtracts `send_len` bytes from each enabled bucket. A bucket may go below zero. An enabled bucket reports conforming only while its level is strictly above zero.
- R7: A disabled bucket always reports conforming, and send strobes have no effect on it.
- R8: The two buckets are independent. A write or a deficit in one bucket does not change the flag of the other.
- R9: The flags are registered. A level change made at a clock edge shows on the flag one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Bucket select: 0 peak, 1 committed |
| cfg_wdata | input | 29 | Configuration word (layout in R2) |
| send_valid | input | 1 | One-cycle packet-sent strobe |
| send_len | input | 16 | Byte length of the sent packet |
| peak_ok | output | 1 | Packet conforms to the peak rate |
| commit_ok | output | 1 | Packet conforms to the committed rate |

## Verification
A wrong bucket level only becomes visible at the ports when it crosses zero. Tests therefore drive each bucket to a known level near zero and count refill events until the flag must flip. A lost fraction, a missing clamp or an off-by-one wheel period then moves the flip by one full refill period, and the sample at the exact cycle catches it. Wrong flag pipelining shows within one cycle of a charge or a write.

// File: rtl/shaper_pkg.sv
`timescale 1ns/1ps
package shaper_pkg;
  localparam int MANT_W  = 8;
  localparam int EXP_W   = 4;
  localparam int DIV_W   = 4;
  localparam int MAX_DIV = 12;
  localparam int LANES   = 2;
  localparam int WORD_W  = 2 * MANT_W + 2 * EXP_W + DIV_W + 1;

  // Field order fixes the write-word layout (LSB is rate_mant).
  typedef struct packed {
    logic              en;
    logic [EXP_W-1:0]  burst_exp;
    logic [MANT_W-1:0] burst_mant;
    logic [DIV_W-1:0]  div_exp;
    logic [EXP_W-1:0]  rate_exp;
    logic [MANT_W-1:0] rate_mant;
  } lane_cfg_t;
endpackage

// File: rtl/shaper_wheel.sv
`timescale 1ns/1ps
module shaper_wheel #(
  parameter int TICKS   = 240,
  parameter int DIV_W   = 4,
  parameter int MAX_DIV = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_exp,
  output logic             tick
);
  localparam int CNT_W = $clog2(TICKS) + MAX_DIV + 1;

  logic [DIV_W-1:0] div_eff;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cnt;

  assign div_eff = (div_exp > DIV_W'(MAX_DIV)) ? DIV_W'(MAX_DIV) : div_exp;
  assign period  = CNT_W'(TICKS) << div_eff;
  assign tick    = (cnt == period - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + CNT_W'(1);
  end

  assert_cnt_below_period_R4: assert property (@(posedge clk) disable iff (rst)
    cnt < period);
  assert_tick_wraps_R4: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0));
endmodule

// File: rtl/shaper_credit.sv
`timescale 1ns/1ps
module shaper_credit #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 4,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [MANT_W-1:0] ld_burst_mant,
  input  logic [EXP_W-1:0]  ld_burst_exp,
  input  logic              en,
  input  logic [MANT_W-1:0] rate_mant,
  input  logic [EXP_W-1:0]  rate_exp,
  input  logic [MANT_W-1:0] burst_mant,
  input  logic [EXP_W-1:0]  burst_exp,
  input  logic              tick,
  input  logic              charge,
  input  logic [LEN_W-1:0]  len,
  output logic              ok
);
  localparam int BASE_W  = MANT_W + 1;
  localparam int BURST_W = BASE_W + (1 << EXP_W);
  localparam int CHG_W   = LEN_W + MANT_W;
  localparam int LVL_W   = ((BURST_W > CHG_W) ? BURST_W : CHG_W) + 3;
  localparam int SUM_W   = LVL_W + 2;
  localparam logic signed [LVL_W-1:0] FLOOR = {2'b11, {(LVL_W-2){1'b0}}};

  // Value of the code (1.mantissa) << shift, held with MANT_W fraction bits.
  function automatic logic [BURST_W-1:0] code_val(input logic [MANT_W-1:0] m,
                                                  input logic [EXP_W:0]    sh);
    return BURST_W'({1'b1, m}) << sh;
  endfunction

  logic [BURST_W-1:0]       add_u, burst_u, ld_burst_u;
  logic signed [LVL_W-1:0]  level, level_nxt;
  logic signed [SUM_W-1:0]  level_ext, add_s, chg_s, burst_s, floor_s, sum, clamped;
  logic                     level_pos;

  assign add_u      = code_val(rate_mant, {1'b0, rate_exp});
  assign burst_u    = code_val(burst_mant, {1'b0, burst_exp} + 1'b1);
  assign ld_burst_u = code_val(ld_burst_mant, {1'b0, ld_burst_exp} + 1'b1);

  assign level_ext = {{2{level[LVL_W-1]}}, level};
  assign floor_s   = {{2{FLOOR[LVL_W-1]}}, FLOOR};
  assign burst_s   = {{(SUM_W-BURST_W){1'b0}}, burst_u};
  assign add_s     = tick   ? {{(SUM_W-BURST_W){1'b0}}, add_u} : '0;
  assign chg_s     = charge ? {{(SUM_W-CHG_W){1'b0}}, len, {MANT_W{1'b0}}} : '0;
  assign level_pos = !level[LVL_W-1] && (|level);

  always_comb begin
    sum = level_ext + add_s - chg_s;
    if (sum > burst_s)      clamped = burst_s;
    else if (sum < floor_s) clamped = floor_s;
    else                    clamped = sum;
    level_nxt = clamped[LVL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      ok    <= 1'b1;
    end else begin
      ok <= !en || level_pos;
      if (load)     level <= {{(LVL_W-BURST_W){1'b0}}, ld_burst_u};
      else if (!en) level <= {{(LVL_W-BURST_W){1'b0}}, burst_u};
      else          level <= level_nxt;
    end
  end

  assert_level_cap_R5: assert property (@(posedge clk) disable iff (rst)
    level <= burst_s);
  assert_idle_ok_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> ok);
  assert_charge_drops_R6: assert property (@(posedge clk) disable iff (rst)
    (en && charge && !tick && !load && (len != '0)) |=>
      ((level < $past(level)) || (level == FLOOR)));
  assert_refill_rises_R3: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !charge && !load) |=> (level >= $past(level)));
endmodule

// File: rtl/dual_rate_shaper.sv
`timescale 1ns/1ps
module dual_rate_shaper import shaper_pkg::*; #(
  parameter int WHEEL_TICKS = 240,
  parameter int LEN_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              send_valid,
  input  logic [LEN_W-1:0]  send_len,
  output logic              peak_ok,
  output logic              commit_ok
);
  logic [LANES-1:0] ok_vec;
  lane_cfg_t        new_cfg;

  assign new_cfg = lane_cfg_t'(cfg_wdata);

  for (genvar g = 0; g < LANES; g++) begin : lane_g
    lane_cfg_t cfg_q;
    logic      load;
    logic      tick;

    assign load = cfg_we && (cfg_sel == 1'(g));

    always_ff @(posedge clk) begin
      if (rst)       cfg_q <= '0;
      else if (load) cfg_q <= new_cfg;
    end

    shaper_wheel #(.TICKS(WHEEL_TICKS), .DIV_W(DIV_W), .MAX_DIV(MAX_DIV)) u_wheel (
      .clk     (clk),
      .rst     (rst),
      .restart (load),
      .div_exp (cfg_q.div_exp),
      .tick    (tick)
    );

    shaper_credit #(.MANT_W(MANT_W), .EXP_W(EXP_W), .LEN_W(LEN_W)) u_credit (
      .clk           (clk),
      .rst           (rst),
      .load          (load),
      .ld_burst_mant (new_cfg.burst_mant),
      .ld_burst_exp  (new_cfg.burst_exp),
      .en            (cfg_q.en),
      .rate_mant     (cfg_q.rate_mant),
      .rate_exp      (cfg_q.rate_exp),
      .burst_mant    (cfg_q.burst_mant),
      .burst_exp     (cfg_q.burst_exp),
      .tick          (tick),
      .charge        (send_valid),
      .len           (send_len),
      .ok            (ok_vec[g])
    );
  end

  assign peak_ok   = ok_vec[0];
  assign commit_ok = ok_vec[1];
endmodule

// File: tb/sim_dual_rate_shaper.sv
`timescale 1ns/1ps
module sim_dual_rate_shaper;
  import shaper_pkg::*;
  localparam int WT = 16;

  typedef struct packed {
    logic        sel;
    logic [7:0]  rm;
    logic [3:0]  re;
    logic [3:0]  rd;
    logic [7:0]  bm;
    logic [3:0]  be;
    logic [15:0] len;
    logic [7:0]  k;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{1'b1, 8'd0,   4'd0,  4'd0, 8'd0,   4'd0,  16'd2,     8'd0},
    '{1'b1, 8'd0,   4'd0,  4'd0, 8'd0,   4'd0,  16'd2,     8'd1},
    '{1'b1, 8'd0,   4'd0,  4'd0, 8'd0,   4'd0,  16'd1,     8'd0},
    '{1'b1, 8'd128, 4'd0,  4'd0, 8'd0,   4'd3,  16'd19,    8'd2},
    '{1'b1, 8'd128, 4'd0,  4'd0, 8'd0,   4'd3,  16'd19,    8'd3},
    '{1'b0, 8'd0,   4'd0,  4'd0, 8'd0,   4'd0,  16'd3,     8'd1},
    '{1'b0, 8'd0,   4'd0,  4'd0, 8'd0,   4'd0,  16'd3,     8'd2},
    '{1'b0, 8'd255, 4'd15, 4'd0, 8'd0,   4'd0,  16'd2,     8'd3},
    '{1'b1, 8'd0,   4'd0,  4'd1, 8'd0,   4'd0,  16'd2,     8'd1},
    '{1'b1, 8'd0,   4'd0,  4'd0, 8'd255, 4'd15, 16'd65535, 8'd0},
    '{1'b0, 8'd0,   4'd1,  4'd0, 8'd0,   4'd1,  16'd10,    8'd6}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic              cfg_sel = 1'b0;
  logic [WORD_W-1:0] cfg_wdata = '0;
  logic              send_valid = 1'b0;
  logic [15:0]       send_len = '0;
  logic              peak_ok, commit_ok;
  int                checks = 0;
  int                fails = 0;

  always #2.5 clk = ~clk;

  dual_rate_shaper #(.WHEEL_TICKS(WT), .LEN_W(16)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .send_valid(send_valid), .send_len(send_len), .peak_ok(peak_ok), .commit_ok(commit_ok)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] mk(input logic en, input logic [7:0] rm,
      input logic [3:0] re, input logic [3:0] rd, input logic [7:0] bm, input logic [3:0] be);
    return {en, be, bm, rd, re, rm};
  endfunction

  // Expected flag from the R3/R5/R6 arithmetic, in 1/256 byte units.
  function automatic logic model(input vec_t v);
    longint burst = longint'(256 + v.bm) << (v.be + 1);
    longint add   = longint'(256 + v.rm) << v.re;
    longint lvl   = burst - longint'(v.len) * 256;
    for (int j = 0; j < v.k; j++) begin
      lvl = lvl + add;
      if (lvl > burst) lvl = burst;
    end
    return lvl > 0;
  endfunction

  // All tasks start and end at a falling edge.
  task automatic wr(input logic sel, input logic [WORD_W-1:0] w);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = w;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [15:0] n);
    send_valid = 1'b1; send_len = n;
    @(posedge clk); @(negedge clk);
    send_valid = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step(1);
    check(peak_ok, 1'b1, "R1 peak after reset");
    check(commit_ok, 1'b1, "R1 commit after reset");

    // Table walk: R3 fractions, R4 divider, R5 depth, R6 deficit, R7/R8 other lane idle.
    for (int i = 0; i < NV; i++) begin
      vec_t v = VT[i];
      int   p = WT << v.rd;
      wr(!v.sel, '0);
      wr(v.sel, mk(1'b1, v.rm, v.re, v.rd, v.bm, v.be));
      send(v.len);
      step((v.k == 0) ? 1 : int'(v.k) * p);
      check(v.sel ? commit_ok : peak_ok, model(v), $sformatf("R3 R6 vector %0d", i));
      check(v.sel ? peak_ok : commit_ok, 1'b1, $sformatf("R8 idle lane vector %0d", i));
    end

    // R9 and R2: flags lag by one cycle, and a write refills the bucket.
    wr(1'b1, '0);
    wr(1'b0, mk(1'b1, 8'd0, 4'd0, 4'd0, 8'd0, 4'd0));
    send(16'd2);
    check(peak_ok, 1'b1, "R9 flag before charge lands");
    step(1);
    check(peak_ok, 1'b0, "R6 empty bucket");
    wr(1'b0, mk(1'b1, 8'd0, 4'd0, 4'd0, 8'd0, 4'd0));
    check(peak_ok, 1'b0, "R9 flag before reload lands");
    step(1);
    check(peak_ok, 1'b1, "R2 write refills");

    // R5: high rate, shallow bucket; credit must not pile up.
    wr(1'b0, mk(1'b1, 8'd255, 4'd15, 4'd0, 8'd0, 4'd0));
    step(3 * WT + 4);
    send(16'd2);
    step(1);
    check(peak_ok, 1'b0, "R5 depth clamp");

    // R7: disabled committed bucket ignores charges.
    wr(1'b1, mk(1'b0, 8'd0, 4'd0, 4'd0, 8'd0, 4'd0));
    send(16'd65535);
    send(16'd65535);
    step(1);
    check(commit_ok, 1'b1, "R7 disabled lane");

    // R8: deep peak bucket stays ok while committed one runs dry.
    wr(1'b0, mk(1'b1, 8'd0, 4'd0, 4'd0, 8'd255, 4'd15));
    wr(1'b1, mk(1'b1, 8'd0, 4'd0, 4'd0, 8'd0, 4'd0));
    send(16'd2);
    step(1);
    check(commit_ok, 1'b0, "R8 committed dry");
    check(peak_ok, 1'b1, "R8 peak unaffected");

    // R4: exact wheel period, divider 0.
    send(16'd0);
    wr(1'b1, mk(1'b1, 8'd0, 4'd0, 4'd0, 8'd0, 4'd0));
    send(16'd2);
    step(WT - 1);
    check(commit_ok, 1'b0, "R4 before first refill");
    step(1);
    check(commit_ok, 1'b1, "R4 at first refill");

    // R4: divider exponent 15 acts as 12.
    wr(1'b1, mk(1'b1, 8'd0, 4'd0, 4'd15, 8'd0, 4'd0));
    send(16'd2);
    step((WT << 12) - 1);
    check(commit_ok, 1'b0, "R4 clamped divider early");
    step(1);
    check(commit_ok, 1'b1, "R4 clamped divider refill");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule